// File: doc/BRIEF.md
# Serial Programming Port with Control-Bit Routing

This block takes a three-wire programming stream (serial clock, serial data and load-enable) and loads the settings of a frequency synthesizer into two holding registers. The three wires are asynchronous to the block clock. Each is passed through a synchronizer, and edges are found in the block clock domain. Every rising edge of the serial clock moves one data bit into a 19-bit shift register. The bit that arrives last is the routing bit.

On a rising edge of load-enable, the routing bit chooses the destination. A 1 sends the word to the reference register: the reference division ratio, the prescaler modulus choice, the comparator polarity and the monitor-output choice. A 0 sends the word to the divider register: the swallow count and the main count. Both words share one shift register, so the 18-bit reference word simply ignores whatever sits in the top position. A reference ratio below the legal floor is refused. The old reference settings then stay in place and an error flag is raised. The registered fields drive the divider and phase-comparator logic that sit next to this block. Programming works the same way in power-save, because nothing here depends on it.

Top module: `serial_prog_port`

## Requirements
- R1: Each rising edge of `serClk` shifts `serData` into the shift register at bit 0, and earlier bits move one place up. Words are sent most significant bit first, so the last bit sent (bit 0) is the routing bit.
- R2: A load with routing bit 1 updates the reference register from the 18-bit word. Bits 14:1 give `refRatio`, bit 15 gives `prescSmall` (1 selects 32/33, 0 selects 64/65), bit 16 gives `phasePol`, and bit 17 gives `monSel` (1 selects the frequency monitor, 0 selects the lock signal).
- R3: A load with routing bit 0 updates the divider register from the 19-bit word. Bits 7:1 give `swallowCnt` and bits 18:8 give `mainCnt`.
- R4: A load into one register leaves the other register unchanged.
- R5: Each rising edge of `loadEn` causes exactly one update. While `loadEn` stays high, further shifting changes no output.
- R6: A reference word whose ratio field is below 5 is refused. All four reference outputs keep their previous values and `refError` becomes 1.
- R7: `refError` returns to 0 on the next accepted reference load. Divider loads do not change it.
- R8: After reset, the outputs are: `refRatio`=5, `swallowCnt`=0, `mainCnt`=5, `prescSmall`=0, `phasePol`=1, `monSel`=0, `refError`=0.
- R9: Shifting without a load edge changes no output. A later load edge latches the word that was shifted in.
- R10: For a reference word, shift-register bit 18, left over from an earlier or longer word, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| loadEn | input | 1 | Load enable, asynchronous |
| refRatio | output | 14 | Reference division ratio |
| prescSmall | output | 1 | 1: prescaler 32/33, 0: 64/65 |
| phasePol | output | 1 | Phase comparator polarity |
| monSel | output | 1 | 1: frequency monitor, 0: lock signal |
| swallowCnt | output | 7 | Swallow count |
| mainCnt | output | 11 | Main count |
| refError | output | 1 | A reference word was refused |

## Verification
The assertions assume that every serial wire holds each level for at least three block-clock cycles. This lets the synchronizer see every edge. They also assume that `serData` is stable across each rising edge of `serClk`. The driver changes data three cycles before the serial clock rises and holds it until the clock has fallen. It keeps every level of `loadEn` for at least four cycles. It never moves `serClk` and `loadEn` in the same cycle, so the assertions' view of single, separated load events matches the stimulus.

// File: rtl/spp_pkg.sv
package spp_pkg;
  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic shift;      // take one serial bit
    logic loadRef;    // accept reference word
    logic loadDiv;    // accept divider word
    logic rejectRef;  // refuse reference word (ratio too small)
  } progStrobe_t;
endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spp_ctrl.sv
module spp_ctrl
  import spp_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int REF_MIN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serClk,
  input  logic             serData,
  input  logic             loadEn,
  input  logic             ctrlBit,
  input  logic [REF_W-1:0] candRatio,
  output progStrobe_t      strb,
  output logic             dataBit
);
  localparam logic [REF_W-1:0] REF_MIN_V = REF_W'(REF_MIN);

  logic [2:0] syncd;
  logic clkPrev, lePrev;
  logic clkRise, leRise, ratioOk;

  spp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({serClk, serData, loadEn}),
    .dout (syncd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= syncd[2];
      lePrev  <= syncd[0];
    end
  end

  assign clkRise = syncd[2] & ~clkPrev;
  assign leRise  = syncd[0] & ~lePrev;
  assign dataBit = syncd[1];
  assign ratioOk = (candRatio >= REF_MIN_V);

  always_comb begin
    strb           = '0;
    strb.shift     = clkRise;
    strb.loadRef   = leRise &  ctrlBit &  ratioOk;
    strb.rejectRef = leRise &  ctrlBit & ~ratioOk;
    strb.loadDiv   = leRise & ~ctrlBit;
  end

  AST_LOAD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    leRise |=> !leRise); // R5
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadRef, strb.loadDiv, strb.rejectRef})); // R4
endmodule

// File: rtl/spp_datapath.sv
module spp_datapath
  import spp_pkg::*;
#(
  parameter int REF_W    = 14,
  parameter int SWAL_W   = 7,
  parameter int MAIN_W   = 11,
  parameter int REF_MIN  = 5,
  parameter int MAIN_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  progStrobe_t       strb,
  input  logic              dataBit,
  output logic              ctrlBit,
  output logic [REF_W-1:0]  candRatio,
  output logic [REF_W-1:0]  refRatio,
  output logic              prescSmall,
  output logic              phasePol,
  output logic              monSel,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refError
);
  localparam int REF_WORD  = REF_W + 4;
  localparam int DIV_WORD  = SWAL_W + MAIN_W + 1;
  localparam int SR_W      = (REF_WORD > DIV_WORD) ? REF_WORD : DIV_WORD;
  localparam int PS_POS    = REF_W + 1;
  localparam int POL_POS   = REF_W + 2;
  localparam int MON_POS   = REF_W + 3;
  localparam int MAIN_LO   = SWAL_W + 1;
  localparam logic [REF_W-1:0]  REF_MIN_V  = REF_W'(REF_MIN);
  localparam logic [MAIN_W-1:0] MAIN_MIN_V = MAIN_W'(MAIN_MIN);

  logic [SR_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[SR_W-2:0], dataBit};
  end

  assign ctrlBit   = shiftReg[0];
  assign candRatio = shiftReg[REF_W:1];

  // Reference register: only the low REF_WORD bits are used.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refRatio   <= REF_MIN_V;
      prescSmall <= 1'b0;
      phasePol   <= 1'b1;
      monSel     <= 1'b0;
    end else if (strb.loadRef) begin
      refRatio   <= shiftReg[REF_W:1];
      prescSmall <= shiftReg[PS_POS];
      phasePol   <= shiftReg[POL_POS];
      monSel     <= shiftReg[MON_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swallowCnt <= '0;
      mainCnt    <= MAIN_MIN_V;
    end else if (strb.loadDiv) begin
      swallowCnt <= shiftReg[SWAL_W:1];
      mainCnt    <= shiftReg[DIV_WORD-1:MAIN_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              refError <= 1'b0;
    else if (strb.rejectRef) refError <= 1'b1;
    else if (strb.loadRef)   refError <= 1'b0;
  end

  AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    refRatio >= REF_MIN_V); // R6
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadRef |=> $stable({refRatio, prescSmall, phasePol, monSel})); // R4
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadDiv |=> $stable({swallowCnt, mainCnt})); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rejectRef |=> refError); // R6
  AST_ERR_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadDiv |=> $stable(refError)); // R7
endmodule

// File: rtl/serial_prog_port.sv
module serial_prog_port
  import spp_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int REF_MIN     = 5,
  parameter int MAIN_MIN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadEn,
  output logic [REF_W-1:0]  refRatio,
  output logic              prescSmall,
  output logic              phasePol,
  output logic              monSel,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refError
);
  progStrobe_t      strb;
  logic             dataBit;
  logic             ctrlBit;
  logic [REF_W-1:0] candRatio;

  spp_ctrl #(.REF_W(REF_W), .REF_MIN(REF_MIN), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .serClk   (serClk),
    .serData  (serData),
    .loadEn   (loadEn),
    .ctrlBit  (ctrlBit),
    .candRatio(candRatio),
    .strb     (strb),
    .dataBit  (dataBit)
  );

  spp_datapath #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
                 .REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .dataBit   (dataBit),
    .ctrlBit   (ctrlBit),
    .candRatio (candRatio),
    .refRatio  (refRatio),
    .prescSmall(prescSmall),
    .phasePol  (phasePol),
    .monSel    (monSel),
    .swallowCnt(swallowCnt),
    .mainCnt   (mainCnt),
    .refError  (refError)
  );
endmodule

// File: tb/serial_prog_port_test.sv
module serial_prog_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, loadEn = 1'b0;
  logic [13:0] refRatio;
  logic prescSmall, phasePol, monSel, refError;
  logic [6:0] swallowCnt;
  logic [10:0] mainCnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_prog_port uut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .loadEn(loadEn),
    .refRatio(refRatio), .prescSmall(prescSmall), .phasePol(phasePol), .monSel(monSel),
    .swallowCnt(swallowCnt), .mainCnt(mainCnt), .refError(refError)
  );

  typedef struct {
    logic [35:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event checkEv;

  // Bench model of the visible state
  logic [13:0] mRef = 14'd5;
  logic mPs = 1'b0, mPol = 1'b1, mMon = 1'b0, mErr = 1'b0;
  logic [6:0] mSw = 7'd0;
  logic [10:0] mMain = 11'd5;

  function automatic logic [35:0] packModel();
    return {mErr, mMon, mPol, mPs, mRef, mSw, mMain};
  endfunction

  function automatic logic [18:0] mkRef(logic [13:0] r, logic ps, logic pol, logic mon);
    return {1'b0, mon, pol, ps, r, 1'b1};
  endfunction

  function automatic logic [18:0] mkDiv(logic [6:0] a, logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftWord(logic [18:0] w, int len);
    for (int i = len - 1; i >= 0; i--) begin
      serData = w[i];
      waitCyc(3);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
      waitCyc(3);
    end
  endtask

  task automatic pulseLoad();
    loadEn = 1'b1;
    waitCyc(5);
    loadEn = 1'b0;
    waitCyc(6);
  endtask

  task automatic expectNow(string tag);
    expItem_t it;
    it.val = packModel();
    it.tag = tag;
    expQ.push_back(it);
    ->checkEv;
    waitCyc(1);
  endtask

  // Apply the requirement model for a load of word w.
  task automatic modelLoad(logic [18:0] w);
    if (w[0]) begin
      if (w[14:1] < 14'd5) mErr = 1'b1;
      else begin
        mRef = w[14:1]; mPs = w[15]; mPol = w[16]; mMon = w[17]; mErr = 1'b0;
      end
    end else begin
      mSw = w[7:1]; mMain = w[18:8];
    end
  endtask

  task automatic sendAndLoad(logic [18:0] w, int len, string tag);
    shiftWord(w, len);
    pulseLoad();
    modelLoad(w);
    expectNow(tag);
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(checkEv);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [35:0] act;
        it = expQ.pop_front();
        act = {refError, monSel, phasePol, prescSmall, refRatio, swallowCnt, mainCnt};
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
        end
      end
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [18:0] w;
    waitCyc(4);
    rst_n = 1'b1;
    waitCyc(3);
    expectNow("R8 reset values");

    sendAndLoad(mkRef(14'd100, 1'b1, 1'b0, 1'b1), 18, "R2 R1 reference word");
    sendAndLoad(mkDiv(7'd13, 11'd300), 19, "R3 R4 divider word");
    sendAndLoad(mkRef(14'd4, 1'b0, 1'b1, 1'b0), 18, "R6 ratio 4 refused");
    sendAndLoad(mkDiv(7'd90, 11'd1234), 19, "R7 divider keeps error");
    sendAndLoad(mkRef(14'd5, 1'b0, 1'b1, 1'b0), 18, "R7 R6 ratio 5 accepted clears error");
    sendAndLoad(mkRef(14'd16383, 1'b1, 1'b1, 1'b1), 18, "R2 max ratio all flags");

    // Stale top bit ignored on a reference word
    w = mkRef(14'd777, 1'b0, 1'b0, 1'b1);
    w[18] = 1'b1;
    sendAndLoad(w, 19, "R10 stale bit 18 ignored");

    // Shift without load: nothing changes; later load takes it
    w = mkDiv(7'd64, 11'd77);
    shiftWord(w, 19);
    waitCyc(6);
    expectNow("R9 shift without load");
    pulseLoad();
    modelLoad(w);
    expectNow("R9 R1 deferred load");

    // Hold loadEn high while shifting a new word: only one update
    w = mkRef(14'd2000, 1'b1, 1'b0, 1'b0);
    shiftWord(w, 18);
    loadEn = 1'b1;
    waitCyc(6);
    modelLoad(w);
    expectNow("R5 first edge loads");
    shiftWord(mkDiv(7'd5, 11'd9), 19);
    waitCyc(4);
    expectNow("R5 held high no update");
    loadEn = 1'b0;
    waitCyc(6);
    expectNow("R5 release no update");
    pulseLoad();
    modelLoad(mkDiv(7'd5, 11'd9));
    expectNow("R5 R3 next edge loads");

    sendAndLoad(mkRef(14'd0, 1'b0, 1'b0, 1'b1), 18, "R6 ratio 0 refused");
    sendAndLoad(mkDiv(7'd127, 11'd2047), 19, "R3 divider maxima");
    sendAndLoad(mkRef(14'd6, 1'b0, 1'b0, 1'b0), 18, "R7 R4 reference after divider");

    waitCyc(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule